// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked request port and an external asynchronous static RAM of 32K words by 16 bits. A requester presents one word access at a time: a request strobe, a write flag, a word address, write data and a per-byte enable mask. The controller turns each request into a sequence on the RAM pins. Those pins are an active-low chip enable, output enable and write enable, one active-low strobe per byte lane, the address, and a split data bus with an outgoing value, a drive enable and an incoming value. A one-cycle done pulse marks the end of each access. Read data is presented with that pulse, and a lane that was not enabled returns zero.

Every RAM timing figure is given in picoseconds and turned into a whole number of clock cycles. The rule is to round up, with a floor of one cycle. During a write the output enable stays high, so the RAM's outputs are already floating when write enable falls. The write window is the overlap of chip enable, write enable and the byte strobes. It always ends when the byte strobes rise, which lets a following write keep write enable low and be framed by the strobes alone.

The states are IDLE, RD_TURN, RD_ACC, WR_SETUP, WR_PULSE, WR_HOLD and WR_NEXT. Their transitions are:
- IDLE→RD_ACC on a read request.
- IDLE→WR_SETUP on a write request.
- RD_ACC→IDLE when the access count expires; the data is captured on that edge.
- WR_SETUP→WR_PULSE when the output-float count expires.
- WR_PULSE→WR_HOLD when the pulse count expires.
- WR_HOLD→WR_NEXT on a write request.
- WR_HOLD→RD_TURN on a read request.
- WR_HOLD→IDLE with no request.
- WR_NEXT→WR_PULSE after one cycle.
- RD_TURN→RD_ACC after one cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: In reset and while idle, chip enable, output enable, write enable and both byte strobes are high, the data drive enable is low and done is low.
- R2: A read with both lanes enabled returns the stored word. The done pulse appears ACC_CYC edges after the edge that accepts the request, where ACC_CYC = max(1, ceil(T_ACC_PS/CLK_PS)).
- R3: During a read, mem_bs_n_o bit 0 (lane 0, data bits 7:0) and bit 1 (lane 1, data bits 15:8) are low only for lanes whose req_mask_i bit is 1. The data returned for a lane that is not enabled is zero.
- R4: A write changes only the lanes whose req_mask_i bit is 1; the other lanes of the stored word keep their value.
- R5: For a write from idle, chip enable is low with output enable and write enable high for OEH_CYC cycles before write enable falls. Output enable stays high whenever write enable is low.
- R6: The write window (chip enable, write enable and at least one byte strobe all low) lasts exactly WP_CYC cycles per word.
- R7: The data drive enable is never high while output enable is low. It is still high in the first cycle after a write window closes, and every lane written sees it high.
- R8: A write request in the done cycle of a write keeps write enable low throughout the next word. That word is framed by the byte strobes only, with done WP_CYC+1 edges after acceptance.
- R9: A read request in the done cycle of a write first spends one cycle with write enable and output enable high and the drive released. Done follows ACC_CYC+1 edges after acceptance.
- R10: A request is accepted only in IDLE or in a write's done cycle; a request raised at any other time has no effect on the RAM contents or the current access.
- R11: A write from idle signals done OEH_CYC+WP_CYC edges after acceptance, and done is never high for two consecutive cycles.
- R12: Each cycle count is max(1, ceil(time_ps/CLK_PS)); with the defaults ACC_CYC=2, WP_CYC=2, OEH_CYC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, sampled when the block can accept |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_mask_i | input | LANES | Byte enables, bit n = lane n |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data, valid with done after a read |
| mem_ce_n_o | output | 1 | RAM chip enable, active low |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_we_n_o | output | 1 | RAM write enable, active low |
| mem_bs_n_o | output | LANES | RAM byte strobes, active low, bit n = lane n |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_dq_o | output | DATA_W | Data toward the RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data from the RAM |

## Verification
Two situations are hard to reach from the ports. The first is a write that keeps write enable low into the next word. The second is a read that turns the bus around straight after a write. Both exist only when the new request lands in the single cycle where done is high after a write. The stimulus task returns at the falling edge on which it sees done, and can raise the next request in that same half-cycle, which places it in the accepting cycle. A request injected mid-read shows that requests outside the accepting cycles are dropped: the bench reads back the targeted address afterwards.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TURN,
        ST_RD_ACC,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_NEXT
    } lane_st_e;

    // Round a picosecond time up to whole clock cycles, never below one.
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_i,
    input  logic [LANES-1:0]   mask_i,
    input  logic [8*LANES-1:0] dq_i,
    output logic [8*LANES-1:0] rdata_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata_o[8*g +: 8] <= '0;
            end else if (cap_i) begin
                rdata_o[8*g +: 8] <= mask_i[g] ? dq_i[8*g +: 8] : 8'h00;
            end
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int LANES    = 2,
    parameter int CLK_PS   = 4000,
    parameter int T_ACC_PS = 8000,
    parameter int T_WP_PS  = 6500,
    parameter int T_OEH_PS = 4000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 req_wr_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [8*LANES-1:0]   req_wdata_i,
    input  logic [LANES-1:0]     req_mask_i,
    output logic                 rsp_done_o,
    output logic [8*LANES-1:0]   rsp_rdata_o,
    output logic                 mem_ce_n_o,
    output logic                 mem_oe_n_o,
    output logic                 mem_we_n_o,
    output logic [LANES-1:0]     mem_bs_n_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic [8*LANES-1:0]   mem_dq_o,
    output logic                 mem_dq_oe_o,
    input  logic [8*LANES-1:0]   mem_dq_i
);
    localparam int DATA_W  = 8 * LANES;
    localparam int ACC_CYC = ps_to_cyc(T_ACC_PS, CLK_PS);
    localparam int WP_CYC  = ps_to_cyc(T_WP_PS, CLK_PS);
    localparam int OEH_CYC = ps_to_cyc(T_OEH_PS, CLK_PS);
    localparam int MAX_CYC = (ACC_CYC > WP_CYC) ? ((ACC_CYC > OEH_CYC) ? ACC_CYC : OEH_CYC)
                                                : ((WP_CYC > OEH_CYC) ? WP_CYC : OEH_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    lane_st_e             st_q, st_nx;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdat_q;
    logic [LANES-1:0]     mask_q;
    logic                 done_q, done_set, cap, accept;
    logic                 tmr_load, tmr_exp;
    logic [CNT_W-1:0]     tmr_val;

    sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    sram_lane_rdcap #(.LANES(LANES)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .mask_i  (mask_q),
        .dq_i    (mem_dq_i),
        .rdata_o (rsp_rdata_o)
    );

    assign accept = req_i && ((st_q == ST_IDLE) || (st_q == ST_WR_HOLD));

    // Next state and counter control
    always_comb begin
        st_nx    = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        done_set = 1'b0;
        cap      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_i) begin
                    tmr_load = 1'b1;
                    if (req_wr_i) begin
                        st_nx   = ST_WR_SETUP;
                        tmr_val = CNT_W'(OEH_CYC - 1);
                    end else begin
                        st_nx   = ST_RD_ACC;
                        tmr_val = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_RD_TURN: begin
                st_nx    = ST_RD_ACC;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(ACC_CYC - 1);
            end
            ST_RD_ACC: begin
                if (tmr_exp) begin
                    st_nx    = ST_IDLE;
                    cap      = 1'b1;
                    done_set = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_exp) begin
                    st_nx    = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WR_NEXT: begin
                st_nx    = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_exp) begin
                    st_nx    = ST_WR_HOLD;
                    done_set = 1'b1;
                end
            end
            ST_WR_HOLD: begin
                if (req_i) begin
                    st_nx = req_wr_i ? ST_WR_NEXT : ST_RD_TURN;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            wdat_q <= '0;
            mask_q <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_nx;
            done_q <= done_set;
            if (accept) begin
                addr_q <= req_addr_i;
                wdat_q <= req_wdata_i;
                mask_q <= req_mask_i;
            end
        end
    end

    // Pin decode
    always_comb begin
        mem_ce_n_o  = 1'b1;
        mem_oe_n_o  = 1'b1;
        mem_we_n_o  = 1'b1;
        mem_bs_n_o  = '1;
        mem_dq_oe_o = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RD_TURN: mem_ce_n_o = 1'b0;
            ST_RD_ACC: begin
                mem_ce_n_o = 1'b0;
                mem_oe_n_o = 1'b0;
                mem_bs_n_o = ~mask_q;
            end
            ST_WR_SETUP: begin
                mem_ce_n_o  = 1'b0;
                mem_dq_oe_o = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n_o  = 1'b0;
                mem_we_n_o  = 1'b0;
                mem_bs_n_o  = ~mask_q;
                mem_dq_oe_o = 1'b1;
            end
            ST_WR_HOLD, ST_WR_NEXT: begin
                mem_ce_n_o  = 1'b0;
                mem_we_n_o  = 1'b0;
                mem_dq_oe_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr_o = addr_q;
    assign mem_dq_o   = wdat_q;
    assign rsp_done_o = done_q;

    // Checks on the pin sequence
    logic             wr_act;
    logic [CNT_W:0]   wr_run_q;

    assign wr_act = !mem_ce_n_o && !mem_we_n_o && (mem_bs_n_o != '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_run_q <= '0;
        end else if (wr_act) begin
            wr_run_q <= (wr_run_q == '1) ? wr_run_q : wr_run_q + 1'b1;
        end else begin
            wr_run_q <= '0;
        end
    end

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_act) |-> (int'(wr_run_q) == WP_CYC));

    p_no_drive_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_dq_oe_o);

    p_hold_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_act) |-> mem_dq_oe_o);

    p_oe_high_we_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_oe_n_o);

    p_float_before_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> ($past(mem_oe_n_o) && !$past(mem_ce_n_o)));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done_o |=> !rsp_done_o);

endmodule

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;
    localparam int AW = 15, NL = 2, DW = 16;
    localparam int CLKP = 4000, TACC = 8000, TWP = 6500, TOEH = 4000;
    // R12: cycle counts from the requirement formula
    localparam int ACC_C = ((TACC + CLKP - 1) / CLKP < 1) ? 1 : (TACC + CLKP - 1) / CLKP;
    localparam int WP_C  = ((TWP + CLKP - 1) / CLKP < 1) ? 1 : (TWP + CLKP - 1) / CLKP;
    localparam int OEH_C = ((TOEH + CLKP - 1) / CLKP < 1) ? 1 : (TOEH + CLKP - 1) / CLKP;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [NL-1:0] m;
        logic [DW-1:0] e;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{1'b1, 15'h0011, 16'hA1B2, 2'b11, 16'h0000},
        '{1'b1, 15'h4022, 16'hC3D4, 2'b11, 16'h0000},
        '{1'b0, 15'h0011, 16'h0000, 2'b11, 16'hA1B2},
        '{1'b1, 15'h0011, 16'hFFEE, 2'b01, 16'h0000},
        '{1'b0, 15'h0011, 16'h0000, 2'b11, 16'hA1EE},
        '{1'b1, 15'h4022, 16'h5566, 2'b10, 16'h0000},
        '{1'b0, 15'h4022, 16'h0000, 2'b11, 16'h55D4},
        '{1'b0, 15'h4022, 16'h0000, 2'b01, 16'h00D4},
        '{1'b0, 15'h0011, 16'h0000, 2'b10, 16'hA100}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NL-1:0] req_mask = '0;
    logic done, ce_n, oe_n, we_n, dq_oe;
    logic [DW-1:0] rdata, dq_o, dq_i;
    logic [NL-1:0] bs_n;
    logic [AW-1:0] maddr;
    int total = 0, bad = 0;
    logic [DW-1:0] mem [0:255];
    bit inject = 1'b0;

    always #2 clk = ~clk;

    sram_lane_ctrl #(.ADDR_W(AW), .LANES(NL), .CLK_PS(CLKP), .T_ACC_PS(TACC),
                     .T_WP_PS(TWP), .T_OEH_PS(TOEH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_wr_i(req_wr),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_mask_i(req_mask),
        .rsp_done_o(done), .rsp_rdata_o(rdata), .mem_ce_n_o(ce_n),
        .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_bs_n_o(bs_n),
        .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // RAM model: floating lanes read as 8'hA5
    always_comb begin
        for (int l = 0; l < NL; l++) begin
            dq_i[8*l +: 8] = (!ce_n && !oe_n && we_n && !bs_n[l]) ? mem[maddr[7:0]][8*l +: 8] : 8'hA5;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ce_n && !we_n) begin
                for (int l = 0; l < NL; l++) begin
                    if (!bs_n[l]) begin
                        if (!dq_oe) check(1'b0, "R7 lane written without drive", 0, 1);
                        mem[maddr[7:0]][8*l +: 8] <= dq_o[8*l +: 8];
                    end
                end
            end
            if (dq_oe && !oe_n) check(1'b0, "R7 drive while output enable low", 1, 0);
            if (!we_n && !oe_n) check(1'b0, "R5 output enable low during write", 0, 1);
        end
    end

    // kind 0: from idle, kind 1: issued in the done cycle of a write
    task automatic op(input bit kind, input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NL-1:0] m, output int lat, output logic [DW-1:0] rd);
        int wcyc = 0;
        int fa;
        fa = (kind && !wr) ? 2 : 1;
        if (!kind) @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 1) req = 1'b0;
            if (inject && lat == 1) begin
                req = 1'b1; req_wr = 1'b1; req_addr = 15'h0033; req_wdata = 16'hBEEF; req_mask = 2'b11;
            end
            if (inject && lat == 2) req = 1'b0;
            if (!ce_n && !we_n && bs_n != '1) wcyc++;
            if (!wr && lat == fa) begin
                check(!oe_n && !ce_n, "R3 read pins active", {oe_n, ce_n}, 0);
                check(bs_n == ~m, "R3 read strobes follow mask", bs_n, ~m);
            end
            if (kind && !wr && lat == 1)
                check(we_n && oe_n && !dq_oe, "R9 turnaround cycle", {we_n, oe_n, dq_oe}, 3'b110);
            if (wr && !kind && lat <= OEH_C)
                check(!ce_n && oe_n && we_n, "R5 setup before write enable", {ce_n, oe_n, we_n}, 3'b011);
            if (wr && kind)
                check(!we_n, "R8 write enable held low across words", we_n, 0);
            if (done || lat > 60) break;
        end
        rd = rdata;
        if (wr) check(wcyc == WP_C, "R6 write window length", wcyc, WP_C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        logic [DW-1:0] rd;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ce_n && oe_n && we_n && bs_n == '1 && !dq_oe && !done, "R1 pins in reset",
              {ce_n, oe_n, we_n, bs_n, dq_oe, done}, 7'b1111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ce_n && oe_n && we_n && bs_n == '1 && !dq_oe && !done, "R1 pins idle",
              {ce_n, oe_n, we_n, bs_n, dq_oe, done}, 7'b1111100);

        // Table walk: R2, R3, R4, R11, R12
        for (int i = 0; i < 9; i++) begin
            op(1'b0, TBL[i].wr, TBL[i].a, TBL[i].d, TBL[i].m, lat, rd);
            if (TBL[i].wr) begin
                check(lat == OEH_C + WP_C + 1, "R11 R12 write done latency", lat, OEH_C + WP_C + 1);
            end else begin
                check(lat == ACC_C + 1, "R2 R12 read done latency", lat, ACC_C + 1);
                check(rd == TBL[i].e, "R2 R3 R4 read data", rd, TBL[i].e);
            end
            @(negedge clk);
            check(!done, "R11 done lasts one cycle", done, 0);
            check(ce_n && we_n && !dq_oe, "R1 idle after access", {ce_n, we_n, dq_oe}, 3'b110);
        end

        // R8: chained writes with write enable held low
        op(1'b0, 1'b1, 15'h0044, 16'h1122, 2'b11, lat, rd);
        op(1'b1, 1'b1, 15'h0055, 16'h3344, 2'b10, lat, rd);
        check(lat == WP_C + 2, "R8 chained write latency", lat, WP_C + 2);
        op(1'b1, 1'b1, 15'h0044, 16'h99AA, 2'b01, lat, rd);
        op(1'b0, 1'b0, 15'h0044, 16'h0, 2'b11, lat, rd);
        check(rd == 16'h11AA, "R8 R4 chained word 1", rd, 16'h11AA);
        op(1'b0, 1'b0, 15'h0055, 16'h0, 2'b11, lat, rd);
        check(rd == 16'h3300, "R8 R4 chained word 2", rd, 16'h3300);

        // R9: read straight after a write
        op(1'b0, 1'b1, 15'h0066, 16'h7788, 2'b11, lat, rd);
        op(1'b1, 1'b0, 15'h0066, 16'h0, 2'b11, lat, rd);
        check(lat == ACC_C + 2, "R9 turnaround read latency", lat, ACC_C + 2);
        check(rd == 16'h7788, "R9 turnaround read data", rd, 16'h7788);

        // R10: a write raised during a read is ignored
        inject = 1'b1;
        op(1'b0, 1'b0, 15'h0066, 16'h0, 2'b11, lat, rd);
        inject = 1'b0;
        check(lat == ACC_C + 1 && rd == 16'h7788, "R10 read unaffected", {lat[15:0], rd}, {16'(ACC_C + 1), 16'h7788});
        repeat (3) @(negedge clk);
        check(ce_n && we_n, "R10 no access started", {ce_n, we_n}, 2'b11);
        op(1'b0, 1'b0, 15'h0033, 16'h0, 2'b11, lat, rd);
        check(rd == 16'h0000, "R10 ignored write left RAM alone", rd, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule